// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host side of a link to a three-wire serial EEPROM. It drives chip select, shift clock and serial data out, and samples the memory's serial data line. A user issues one command at a time through a valid/ready handshake. Each command carries an operation code, a word address, write data and, for reads, a word count. The controller builds the bit frame and shifts it out with SK taken from the system clock through a fixed divider. It then either collects read words or, after a programming command, deselects the memory and polls its ready/busy status until the memory reports ready.

The `wide_mode` input selects 16-bit words with a 10-bit address when high, and 8-bit words with an 11-bit address when low. It must match how the attached memory is organised. Reads return each word as a single-cycle strobe on `rd_valid` with `rd_data`. Every command ends with a `done` pulse. When status polling exceeds its limit, `timeout_err` is raised in the same cycle as `done`.

Top module: `eeprom3w_host`

## Requirements
- R1: After reset, cs and sk are 0, cmd_ready is 1, and done, rd_valid and timeout_err are 0.
- R2: A command is taken in a cycle with cmd_valid and cmd_ready both high, and cs rises in the next cycle. cmd_ready stays low until the cycle in which done pulses. cs is low whenever cmd_ready is high.
- R3: The frame is sent MSB-first: a start bit of 1, a 2-bit opcode (read 10, write 01, erase 11), then the address. The address is 11 bits when wide_mode=0 and 10 bits when wide_mode=1. Write and write-all frames add the data word after the address: 8 bits when wide_mode=0, 16 bits when wide_mode=1.
- R4: Enable, disable, erase-all and write-all use opcode 00. The top two address bits are 11 for enable, 00 for disable, 10 for erase-all and 01 for write-all, and the remaining address bits are 0.
- R5: cmd_op encodings: 0 read, 1 write, 2 erase, 3 erase-all, 4 write-all, 5 enable, 6 disable. Code 7 behaves as disable.
- R6: While cs is high, each high phase of sk lasts exactly SK_HALF clocks and each low phase lasts at least SK_HALF clocks. di changes only while sk is low or at its falling edge. sk is low whenever cs rises and whenever cs is low.
- R7: On a read, the bit sampled at the falling sk edge of the last address bit is a dummy and is discarded. Data bits are sampled at the following falling edges, MSB first. Each complete word gives one rd_valid cycle with rd_data; the upper 8 bits are 0 when wide_mode=0.
- R8: A read delivers cmd_count words, with a count of 0 treated as 1. The words come from consecutive addresses while cs stays high, with no dummy bit between words.
- R9: After a write, erase, erase-all or write-all frame, cs is held low for DESEL_CLKS clocks. cs is then raised and the controller waits until DO reads 1.
- R10: If DO has not read 1 within POLL_LIMIT clocks of polling, the command ends with timeout_err=1 together with done.
- R11: Every command ends with cs low for DESEL_CLKS clocks before done pulses; done pulses in the cycle after that span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide_mode | input | 1 | 1: 16-bit words and 10-bit address; 0: 8-bit words and 11-bit address |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_op | input | 3 | Operation code (see R5) |
| cmd_addr | input | 11 | Word address |
| cmd_wdata | input | 16 | Write data (low 8 bits used when wide_mode=0) |
| cmd_count | input | CNT_W | Number of words for a read |
| cs | output | 1 | Chip select to the memory |
| sk | output | 1 | Serial shift clock |
| di | output | 1 | Serial data to the memory |
| do_in | input | 1 | Serial data and status from the memory |
| done | output | 1 | One-cycle end-of-command pulse |
| timeout_err | output | 1 | Status polling timed out; valid with done |
| rd_valid | output | 1 | One-cycle strobe for each read word |
| rd_data | output | 16 | Read word |

## Verification
The assertions assume that cmd_valid is raised only while the controller is idle or is held until accepted, and that wide_mode stays constant while a command runs. The bench raises cmd_valid only after seeing cmd_ready, drops it in the next cycle, and changes wide_mode only between commands. The bench's memory model changes do_in only on rising sk edges and on edges of cs, which matches the controller's sampling on falling edges and during polling. It uses short divider, deselect and poll limits so that real busy and forced-busy cases fit in the run.

// File: rtl/eeprom3w_host.sv
module eeprom3w_host #(
  parameter int SK_HALF    = 50,
  parameter int DESEL_CLKS = 25,
  parameter int POLL_LIMIT = 1200000,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide_mode,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [10:0]      cmd_addr,
  input  logic [15:0]      cmd_wdata,
  input  logic [CNT_W-1:0] cmd_count,
  output logic             cs,
  output logic             sk,
  output logic             di,
  input  logic             do_in,
  output logic             done,
  output logic             timeout_err,
  output logic             rd_valid,
  output logic [15:0]      rd_data
);

  localparam int FW   = 30;
  localparam int T1   = (SK_HALF > DESEL_CLKS) ? SK_HALF : DESEL_CLKS;
  localparam int TMAX = (T1 > POLL_LIMIT) ? T1 : POLL_LIMIT;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] HALF_LAST  = TW'(SK_HALF - 1);
  localparam logic [TW-1:0] DESEL_LAST = TW'(DESEL_CLKS - 1);
  localparam logic [TW-1:0] POLL_LAST  = TW'(POLL_LIMIT - 1);

  localparam logic [2:0] OP_READ = 3'd0, OP_WRITE = 3'd1, OP_ERASE = 3'd2,
                         OP_ERAL = 3'd3, OP_WRAL = 3'd4, OP_EWEN = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_RDATA, S_LOW, S_POLL, S_END} st_t;

  st_t             st;
  logic [2:0]      op_q;
  logic            wide_q;
  logic [TW-1:0]   tmr;
  logic            sk_q;
  logic [FW-1:0]   sr;
  logic [4:0]      nbit;
  logic [CNT_W-1:0] wleft;
  logic [15:0]     rsh;
  logic            err_q, done_q, rv_q;
  logic [15:0]     rdat_q;

  logic [1:0]  opc, top2;
  logic        special, has_data;
  logic [10:0] addr_f;
  logic [FW-1:0] frame;
  logic [4:0]  frame_len;
  logic        half_end, sk_fall, prog_q;
  logic [15:0] rsh_n;

  always_comb begin
    special  = 1'b1;
    opc      = 2'b00;
    top2     = 2'b00;
    has_data = 1'b0;
    case (cmd_op)
      OP_READ:  begin special = 1'b0; opc = 2'b10; end
      OP_WRITE: begin special = 1'b0; opc = 2'b01; has_data = 1'b1; end
      OP_ERASE: begin special = 1'b0; opc = 2'b11; end
      OP_ERAL:  top2 = 2'b10;
      OP_WRAL:  begin top2 = 2'b01; has_data = 1'b1; end
      OP_EWEN:  top2 = 2'b11;
      default:  top2 = 2'b00;
    endcase
  end

  assign addr_f    = special ? (wide_mode ? {1'b0, top2, 8'h00} : {top2, 9'h000}) : cmd_addr;
  assign frame     = wide_mode ? {1'b1, opc, addr_f[9:0], cmd_wdata, 1'b0}
                               : {1'b1, opc, addr_f, cmd_wdata[7:0], 8'h00};
  assign frame_len = wide_mode ? (has_data ? 5'd29 : 5'd13) : (has_data ? 5'd22 : 5'd14);

  assign half_end = (tmr == HALF_LAST);
  assign sk_fall  = half_end && sk_q;
  assign prog_q   = (op_q == OP_WRITE) || (op_q == OP_ERASE) || (op_q == OP_ERAL) || (op_q == OP_WRAL);
  assign rsh_n    = {rsh[14:0], do_in};

  assign cmd_ready   = (st == S_IDLE);
  assign cs          = (st == S_SHIFT) || (st == S_RDATA) || (st == S_POLL);
  assign sk          = sk_q;
  assign di          = (st == S_SHIFT) && sr[FW-1];
  assign done        = done_q;
  assign timeout_err = done_q && err_q;
  assign rd_valid    = rv_q;
  assign rd_data     = rdat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= '0;
      wide_q <= 1'b0;
      tmr    <= '0;
      sk_q   <= 1'b0;
      sr     <= '0;
      nbit   <= '0;
      wleft  <= '0;
      rsh    <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      rv_q   <= 1'b0;
      rdat_q <= '0;
    end else begin
      done_q <= 1'b0;
      rv_q   <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          op_q   <= cmd_op;
          wide_q <= wide_mode;
          sr     <= frame;
          nbit   <= frame_len;
          wleft  <= (cmd_count == '0) ? CNT_W'(1) : cmd_count;
          tmr    <= '0;
          sk_q   <= 1'b0;
          err_q  <= 1'b0;
          st     <= S_SHIFT;
        end
        S_SHIFT, S_RDATA: begin
          if (half_end) begin
            tmr  <= '0;
            sk_q <= ~sk_q;
          end else begin
            tmr <= tmr + 1'b1;
          end
          if (sk_fall && st == S_SHIFT) begin
            sr   <= {sr[FW-2:0], 1'b0};
            nbit <= nbit - 1'b1;
            if (nbit == 5'd1) begin
              if (op_q == OP_READ) begin
                st   <= S_RDATA;
                nbit <= wide_q ? 5'd16 : 5'd8;
              end else begin
                st <= prog_q ? S_LOW : S_END;
              end
            end
          end else if (sk_fall) begin
            rsh <= rsh_n;
            if (nbit == 5'd1) begin
              rv_q   <= 1'b1;
              rdat_q <= wide_q ? rsh_n : {8'h00, rsh_n[7:0]};
              nbit   <= wide_q ? 5'd16 : 5'd8;
              wleft  <= wleft - 1'b1;
              if (wleft == CNT_W'(1)) st <= S_END;
            end else begin
              nbit <= nbit - 1'b1;
            end
          end
        end
        S_LOW: begin
          if (tmr == DESEL_LAST) begin
            tmr <= '0;
            st  <= S_POLL;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_POLL: begin
          if (do_in) begin
            tmr <= '0;
            st  <= S_END;
          end else if (tmr == POLL_LAST) begin
            tmr   <= '0;
            err_q <= 1'b1;
            st    <= S_END;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_END: begin
          if (tmr == DESEL_LAST) begin
            tmr    <= '0;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eeprom3w_host_chk.sv
module eeprom3w_host_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic cs,
  input logic sk,
  input logic di,
  input logic done,
  input logic timeout_err,
  input logic rd_valid
);

  // R2
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_ready |-> !cs);

  // R2
  accept_selects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (cs && !cmd_ready));

  // R6
  sk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) sk |-> cs);

  // R6
  cs_rise_sk_low_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs) |-> !sk);

  // R6
  di_steady_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(sk) |-> $stable(di));

  // R7
  word_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> !cmd_ready);

  // R10
  timeout_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n) timeout_err |-> done);

  // R11
  done_into_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (cmd_ready && !cs));

endmodule

bind eeprom3w_host eeprom3w_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cs(cs), .sk(sk), .di(di), .done(done), .timeout_err(timeout_err), .rd_valid(rd_valid)
);

// File: tb/eeprom3w_host_test.sv
`timescale 1ns/1ps
module eeprom3w_host_test;

  localparam int SKH   = 2;
  localparam int DESEL = 4;
  localparam int PLIM  = 300;
  localparam int BUSY  = 120;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide_mode = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [10:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic [7:0] cmd_count = '0;
  logic cs, sk, di, do_in, done, timeout_err, rd_valid;
  logic [15:0] rd_data;

  always #5 clk = ~clk;

  eeprom3w_host #(.SK_HALF(SKH), .DESEL_CLKS(DESEL), .POLL_LIMIT(PLIM), .CNT_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_count(cmd_count),
    .cs(cs), .sk(sk), .di(di), .do_in(do_in), .done(done), .timeout_err(timeout_err),
    .rd_valid(rd_valid), .rd_data(rd_data));

  // ---------------- memory model ----------------
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  bit stuck = 1'b0;
  bit [7:0]  m8n [2048];
  bit [15:0] m16n[1024];
  int dphase = 0, nb = 0, hdr = 0, nd = 0, dat = 0, pend = 0, wa = 0;
  int raddr = 0, rbit = 0, busy_until = 0, hdr_log = -1;
  bit wen = 1'b0, stat = 1'b0, dout = 1'b0;

  assign do_in = cs && ((dphase == 3) ? dout : (stat ? !(stuck || (cyc < busy_until)) : 1'b0));

  always @(posedge sk or negedge cs) begin
    int aw, dw, dep, top;
    logic [15:0] w16;
    logic [7:0]  w8;
    aw  = wide_mode ? 10 : 11;
    dw  = wide_mode ? 16 : 8;
    dep = wide_mode ? 1024 : 2048;
    if (!cs) begin
      if (dphase == 4 && pend != 0) begin
        stat = 1'b1;
        if (wen) begin
          busy_until = cyc + BUSY;
          for (int i = 0; i < dep; i++) begin
            if (pend == 4 || pend == 3 || i == wa) begin
              if (pend == 1 || pend == 4) begin
                if (wide_mode) m16n[i] = ~dat[15:0]; else m8n[i] = ~dat[7:0];
              end else if (pend == 2 || pend == 3) begin
                if (wide_mode) m16n[i] = '0; else m8n[i] = '0;
              end
            end
          end
        end
      end
      dphase = 0;
      pend = 0;
    end else begin
      case (dphase)
        0: if (di) begin dphase = 1; nb = 0; hdr = 0; stat = 1'b0; end
        1: begin
          hdr = (hdr << 1) | int'(di);
          nb++;
          if (nb == 2 + aw) begin
            hdr_log = hdr;
            wa = hdr & ((1 << aw) - 1);
            top = wa >> (aw - 2);
            dphase = 4;
            case ((hdr >> aw) & 3)
              2: begin dphase = 3; raddr = wa; dout = 1'b0; rbit = dw; end
              1: begin pend = 1; dphase = 2; nd = 0; dat = 0; end
              3: pend = 2;
              default: begin
                if (top == 3) wen = 1'b1;
                else if (top == 0) wen = 1'b0;
                else if (top == 2) pend = 3;
                else begin pend = 4; dphase = 2; nd = 0; dat = 0; end
              end
            endcase
          end
        end
        2: begin
          dat = (dat << 1) | int'(di);
          nd++;
          if (nd == dw) dphase = 4;
        end
        3: begin
          if (rbit == 0) begin raddr = (raddr + 1) % dep; rbit = dw; end
          w16 = ~m16n[raddr];
          w8  = ~m8n[raddr];
          dout = wide_mode ? w16[rbit-1] : w8[rbit-1];
          rbit--;
        end
        default: ;
      endcase
    end
  end

  // ---------------- bench state owned by the stimulus ----------------
  logic [7:0]  sh8 [2048];
  logic [15:0] sh16[1024];
  int rd_addr0 = 0, rd_tag = 0;
  int tst_vec = 0, tst_bad = 0;

  // ---------------- per-clock monitor ----------------
  int mon_vec = 0, mon_bad = 0;
  int seen_tag = 0, rd_idx = 0, cs_low_run = 0, sk_run = 0;
  logic prev_sk = 1'b0, prev_di = 1'b0;

  always @(negedge clk) begin
    logic [15:0] exp_w;
    if (seen_tag != rd_tag) begin seen_tag = rd_tag; rd_idx = 0; end
    if (cs) cs_low_run = 0; else cs_low_run++;
    if (rst_n) begin
      if (rd_valid) begin
        exp_w = wide_mode ? sh16[(rd_addr0 + rd_idx) % 1024] : {8'h00, sh8[(rd_addr0 + rd_idx) % 2048]};
        mon_vec++;
        if (rd_data !== exp_w) begin
          mon_bad++;
          $display("FAIL R7/R8 word %0d: rd_data=%h expected %h", rd_idx, rd_data, exp_w);
        end
        rd_idx++;
      end
      if (cmd_ready && cs) begin
        mon_bad++;
        $display("FAIL R2 cs=%b while idle, expected 0", cs);
      end
      if (sk !== prev_sk) begin
        mon_vec++;
        if (prev_sk && sk_run != SKH) begin
          mon_bad++;
          $display("FAIL R6 sk high for %0d clocks, expected %0d", sk_run, SKH);
        end else if (!prev_sk && sk_run < SKH) begin
          mon_bad++;
          $display("FAIL R6 sk low for %0d clocks, expected >= %0d", sk_run, SKH);
        end
        sk_run = 1;
      end else begin
        sk_run++;
      end
      if (di !== prev_di && prev_sk && sk) begin
        mon_bad++;
        $display("FAIL R6 di moved to %b while sk high, expected %b", di, prev_di);
      end
      if (cyc > 150000) begin
        $display("FAIL watchdog: cycle %0d, expected end before 150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", tst_vec + mon_vec + 1, tst_bad + mon_bad + 1);
        $finish;
      end
    end
    prev_sk = sk;
    prev_di = di;
  end

  // ---------------- stimulus ----------------
  bit sh_en = 1'b0;

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tst_vec++;
    if (!ok) begin
      tst_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_hdr(input int op, input int addr);
    int aw, o2, a;
    aw = wide_mode ? 10 : 11;
    a = addr & ((1 << aw) - 1);
    case (op)
      0: o2 = 2;
      1: o2 = 1;
      2: o2 = 3;
      default: o2 = 0;
    endcase
    if (op == 3) a = 2 << (aw - 2);
    if (op == 4) a = 1 << (aw - 2);
    if (op == 5) a = 3 << (aw - 2);
    if (op >= 6) a = 0;
    return (o2 << aw) | a;
  endfunction

  task automatic run_cmd(input int op, input int addr, input int data, input int cnt, input bit exp_to);
    int n, dep;
    bit prog;
    prog = (op >= 1 && op <= 4);
    dep = wide_mode ? 1024 : 2048;
    if (op == 0) begin rd_addr0 = addr; rd_tag++; end
    while (!cmd_ready) tick();
    cmd_op = 3'(op); cmd_addr = 11'(addr); cmd_wdata = 16'(data); cmd_count = 8'(cnt);
    cmd_valid = 1'b1;
    tick();
    cmd_valid = 1'b0;
    // R2: accepted, selected, busy
    chk(cs === 1'b1 && cmd_ready === 1'b0, "R2 accept", {cs, cmd_ready}, 2);
    n = 0;
    while (done !== 1'b1 && n < 5000) begin tick(); n++; end
    chk(done === 1'b1 && cmd_ready === 1'b1, "R2 done/ready", {done, cmd_ready}, 3);
    // R10
    chk(timeout_err === exp_to, "R10 timeout flag", timeout_err, exp_to);
    // R11
    chk(cs_low_run == DESEL + 1, "R11 deselect span", cs_low_run, DESEL + 1);
    // R3 R4 R5
    chk(hdr_log == exp_hdr(op, addr), "R3/R4/R5 frame header", hdr_log, exp_hdr(op, addr));
    if (op == 0) begin
      // R8
      chk(rd_idx == ((cnt == 0) ? 1 : cnt), "R8 word count", rd_idx, (cnt == 0) ? 1 : cnt);
    end
    if (prog && sh_en && !exp_to) begin
      // R9: ready seen only after busy ended
      chk(cyc >= busy_until, "R9 poll until ready", cyc, busy_until);
    end
    if (op == 5) sh_en = 1'b1;
    if (op >= 6) sh_en = 1'b0;
    if (prog && sh_en) begin
      for (int i = 0; i < dep; i++) begin
        if (op == 3 || op == 4 || i == addr) begin
          if (op == 1 || op == 4) begin
            if (wide_mode) sh16[i] = 16'(data); else sh8[i] = 8'(data);
          end else begin
            if (wide_mode) sh16[i] = 16'hFFFF; else sh8[i] = 8'hFF;
          end
        end
      end
    end
    tick();
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) sh8[i] = 8'hFF;
    for (int i = 0; i < 1024; i++) sh16[i] = 16'hFFFF;
    repeat (3) tick();
    // R1
    chk(cs === 1'b0 && sk === 1'b0, "R1 cs/sk reset", {cs, sk}, 0);
    chk(cmd_ready === 1'b1 && done === 1'b0 && rd_valid === 1'b0 && timeout_err === 1'b0,
        "R1 handshake reset", {cmd_ready, done, rd_valid, timeout_err}, 8);
    rst_n = 1'b1;
    repeat (2) tick();

    // 8-bit organisation
    wide_mode = 1'b0;
    run_cmd(1, 5, 'hA5, 0, 1'b0);      // no enable yet
    run_cmd(0, 5, 0, 1, 1'b0);         // R7 expects FF
    run_cmd(5, 0, 0, 0, 1'b0);         // enable (R4)
    run_cmd(1, 5, 'hA5, 0, 1'b0);
    run_cmd(1, 6, 'h3C, 0, 1'b0);
    run_cmd(1, 2047, 'h77, 0, 1'b0);
    run_cmd(0, 5, 0, 2, 1'b0);         // R8 burst
    run_cmd(0, 2047, 0, 2, 1'b0);      // R8 wrap to 0
    run_cmd(2, 5, 0, 0, 1'b0);         // erase
    run_cmd(0, 5, 0, 1, 1'b0);
    stuck = 1'b1;
    run_cmd(1, 9, 'h42, 0, 1'b1);      // R10 timeout
    stuck = 1'b0;
    run_cmd(0, 9, 0, 1, 1'b0);
    run_cmd(6, 0, 0, 0, 1'b0);         // disable
    run_cmd(1, 6, 'h55, 0, 1'b0);
    run_cmd(0, 6, 0, 1, 1'b0);

    // 16-bit organisation
    wide_mode = 1'b1;
    repeat (2) tick();
    run_cmd(5, 0, 0, 0, 1'b0);
    run_cmd(4, 0, 'h1234, 0, 1'b0);    // write-all
    run_cmd(0, 1021, 0, 3, 1'b0);
    run_cmd(1, 1023, 'hBEEF, 0, 1'b0);
    run_cmd(0, 1023, 0, 2, 1'b0);
    run_cmd(7, 0, 0, 0, 1'b0);         // R5: code 7 disables
    run_cmd(1, 4, 'h5555, 0, 1'b0);
    run_cmd(0, 4, 0, 0, 1'b0);         // R8 count 0 -> one word
    run_cmd(5, 0, 0, 0, 1'b0);
    run_cmd(3, 0, 0, 0, 1'b0);         // erase-all
    run_cmd(0, 7, 0, 1, 1'b0);
    run_cmd(0, 1, 0, 4, 1'b0);
    run_cmd(6, 0, 0, 0, 1'b0);

    repeat (4) tick();
    $display("== %0d vectors applied, %0d miscompares ==", tst_vec + mon_vec, tst_bad + mon_bad);
    $finish;
  end

endmodule